// File: doc/BRIEF.md
# Orbit-Aligned Dual-Clock Channel Synchronizer

This block is one lane of a trigger-data synchronizer. It takes 9-bit words (an 8-bit energy value with one fine-grain flag in the top bit) that arrive once per bunch crossing on a local transmit clock. It hands them over on a receive clock that all lanes share. Writing begins at a local orbit marker, pushed back by a per-lane programmable delay. Reading begins when a common receive-side orbit marker arrives. Because every lane sees the common marker in the same cycle, all lanes emit the same crossing together.

During each orbit gap the transmit side raises a gap level. The gap stops writing, empties the storage on both sides and re-arms both markers for the next orbit. A lane can be masked so that it outputs zeros. A sticky error flag in the receive domain records a write into a full store or a read from an empty one. A one-cycle clear pulse resets the flag.

Top module: `orbit_sync_fifo`

## Requirements
- R1: After reset, `rx_data` is zero and `rx_err` is low.
- R2: No word is stored until `tx_orbit` is sampled high. With `sync_delay` = D, the first word stored is the one on `tx_data` at the D-th transmit edge after the marker edge (D = 0 means the marker edge itself). Every later word, one per transmit edge, is stored in order.
- R3: If `rx_orbit` is sampled high at receive edge k, `rx_data` holds stored word 0 after edge k+1 and word n after edge k+1+n. Until then `rx_data` stays zero.
- R4: When `ch_enable` is sampled low at a receive edge, `rx_data` is zero after that edge. Reading still advances, so the words that fall in that window are consumed.
- R5: While `tx_gap` is high, nothing is written and every stored word is discarded. Both sides then wait for fresh markers, so no word from an earlier orbit ever appears after a gap.
- R6: A `tx_orbit` pulse during writing and an `rx_orbit` pulse during reading are ignored. They do not restart either side.
- R7: The store holds 128 words. A write into a full store drops that word, keeps the stored words intact and sets `rx_err`.
- R8: Once reading is enabled, a read of an empty store outputs zero, sets `rx_err` and leaves the read position unchanged. Reading then resumes with the next unread word in order.
- R9: `rx_err` stays high until `err_clear` is sampled high at a receive edge with no new error in that cycle. It is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit-side clock |
| tx_rst_n | input | 1 | Transmit-side synchronous active-low reset |
| tx_data | input | 9 | Crossing word: bit 8 fine-grain flag, bits 7:0 energy |
| tx_orbit | input | 1 | Local orbit marker pulse |
| tx_gap | input | 1 | Orbit-gap level: flushes the store and re-arms |
| sync_delay | input | 4 | Transmit edges between the marker and the first stored word |
| rx_clk | input | 1 | Common receive clock |
| rx_rst_n | input | 1 | Receive-side synchronous active-low reset |
| rx_orbit | input | 1 | Common orbit marker that starts reading |
| ch_enable | input | 1 | Lane enable; low forces zero output |
| err_clear | input | 1 | Clears the sticky error flag |
| rx_data | output | 9 | Aligned output word |
| rx_err | output | 1 | Sticky overflow/underflow flag |

## Verification
Checked on every cycle by properties:
- A gap level never lets a write through.
- Each Gray pointer changes by at most one bit per edge, except at a flush.
- A masked lane outputs zero.
- The error flag falls only on a clear.

Shown only by the bench scenarios:
- Exact crossing alignment after each marker, including the delay offset and the ignored repeat markers.
- That no stale word survives a gap.
- That overflow drops new words and keeps old ones.
- That reading resumes in order after an underflow.

// File: rtl/osf_pkg.sv
// Shared types for the orbit-aligned synchronizer lane.
// Assumes nothing beyond IEEE 1800-2017 packages.
package osf_pkg;
    // Write-side sequencing: waiting for a marker, counting the delay, streaming.
    typedef enum logic [1:0] {
        WR_ARMED = 2'd0,
        WR_DELAY = 2'd1,
        WR_RUN   = 2'd2
    } wr_state_e;
endpackage

// File: rtl/osf_sync.sv
// Two-flop synchronizer for a bus whose value changes at most one bit per
// source edge (Gray pointers) or for single-bit levels and toggles.
// Assumes the destination reset holds the output at zero.
module osf_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Capture and re-time the foreign-domain value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/osf_ram.sv
// Dual-clock word store: written on the transmit clock, read combinationally
// by address in the receive domain (the reader registers the result).
// Assumes the pointer logic never reads a slot in the cycle it is written.
module osf_ram #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 7
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one word per enabled write edge.
    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the addressed word to the reader.
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/osf_write_ctrl.sv
// Transmit-side control. It waits for the local orbit marker, counts out the
// programmed delay, then writes one word per edge until the gap level
// arrives. A write into a full store is dropped and flips an event toggle.
// Assumes ADDR_W >= 2 and a read pointer that arrives Gray-coded through a synchronizer.
module osf_write_ctrl
    import osf_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DLY_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              orbit,
    input  logic              gap,
    input  logic [DLY_W-1:0]  delay,
    input  logic [ADDR_W:0]   rgray_sync,
    output logic              wr_en,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wgray,
    output logic              ovf_tgl
);
    localparam int PW = ADDR_W + 1;

    wr_state_e        state;
    logic [DLY_W-1:0] cnt;
    logic [PW-1:0]    wbin;
    logic [PW-1:0]    wbin_nx;
    logic [PW-1:0]    wgray_nx;
    logic             want;
    logic             full;

    // Full when the write pointer is one lap ahead of the synced read pointer.
    always_comb full = (wgray == {~rgray_sync[PW-1:PW-2], rgray_sync[PW-3:0]});

    // Decide whether this edge carries a word that belongs to the orbit.
    always_comb begin
        unique case (state)
            WR_RUN:   want = 1'b1;
            WR_DELAY: want = (cnt == DLY_W'(1));
            default:  want = orbit && (delay == '0);
        endcase
        if (gap) want = 1'b0;
    end

    // Accept only when room is left.
    always_comb wr_en = want && !full;

    // Next binary and Gray pointer values.
    always_comb begin
        wbin_nx  = wbin + PW'(1);
        wgray_nx = wbin_nx ^ (wbin_nx >> 1);
    end

    always_comb waddr = wbin[ADDR_W-1:0];

    // Sequence marker, delay and streaming; the gap re-arms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WR_ARMED;
            cnt   <= '0;
        end else if (gap) begin
            state <= WR_ARMED;
            cnt   <= '0;
        end else begin
            unique case (state)
                WR_ARMED: begin
                    if (orbit) begin
                        if (delay == '0) begin
                            state <= WR_RUN;
                        end else begin
                            state <= WR_DELAY;
                            cnt   <= delay;
                        end
                    end
                end
                WR_DELAY: begin
                    if (cnt == DLY_W'(1)) state <= WR_RUN;
                    else                  cnt   <= cnt - DLY_W'(1);
                end
                default: ;
            endcase
        end
    end

    // Advance the write pointer; the gap returns it to the origin.
    always_ff @(posedge clk) begin
        if (!rst_n || gap) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (wr_en) begin
            wbin  <= wbin_nx;
            wgray <= wgray_nx;
        end
    end

    // Flip the event toggle for every dropped word.
    always_ff @(posedge clk) begin
        if (!rst_n)            ovf_tgl <= 1'b0;
        else if (want && full) ovf_tgl <= ~ovf_tgl;
    end
endmodule

// File: rtl/osf_read_ctrl.sv
// Receive-side control. It arms on the common orbit marker and then reads one
// word per edge into a registered output. It keeps the sticky error flag
// (local underflow or an overflow event from the transmit side) and clears
// everything while the synced gap level is high.
// Assumes a synchronized Gray write pointer, gap level and overflow toggle.
module osf_read_ctrl #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              orbit,
    input  logic              flush,
    input  logic              enable,
    input  logic              err_clear,
    input  logic [ADDR_W:0]   wgray_sync,
    input  logic              ovf_tgl_sync,
    input  logic [DATA_W-1:0] mem_data,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic              rd_active,
    output logic [DATA_W-1:0] data_out,
    output logic              err
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_nx;
    logic          empty;
    logic          rd_en;
    logic          underflow;
    logic          ovf_prev;
    logic          ovf_evt;

    // Empty when both Gray pointers match.
    always_comb empty = (rgray == wgray_sync);

    // Read attempt outcome for this edge.
    always_comb begin
        rd_en     = rd_active && !empty && !flush;
        underflow = rd_active &&  empty && !flush;
        rbin_nx   = rbin + PW'(1);
        raddr     = rbin[ADDR_W-1:0];
        ovf_evt   = ovf_prev ^ ovf_tgl_sync;
    end

    // Arm on the common marker and disarm on a flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) rd_active <= 1'b0;
        else if (orbit)      rd_active <= 1'b1;
    end

    // Advance the read pointer only on a successful read.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (rd_en) begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    // Register the output word, zero when masked or nothing was read.
    always_ff @(posedge clk) begin
        if (!rst_n)                data_out <= '0;
        else if (rd_en && enable)  data_out <= mem_data;
        else                       data_out <= '0;
    end

    // Remember the last toggle value to spot overflow events.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_prev <= 1'b0;
        else        ovf_prev <= ovf_tgl_sync;
    end

    // Sticky error: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                   err <= 1'b0;
        else if (underflow || ovf_evt) err <= 1'b1;
        else if (err_clear)           err <= 1'b0;
    end
endmodule

// File: rtl/orbit_sync_fifo.sv
// One synchronizer lane. Words are written on the transmit clock from the
// delayed local orbit marker and read on the common receive clock from the
// common marker. The store is flushed during each orbit gap.
// Assumes the gap lasts at least four cycles of each clock and that the
// common marker comes late enough for several words to be already stored.
module orbit_sync_fifo #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 7,
    parameter int DLY_W  = 4
) (
    input  logic              tx_clk,
    input  logic              tx_rst_n,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_orbit,
    input  logic              tx_gap,
    input  logic [DLY_W-1:0]  sync_delay,
    input  logic              rx_clk,
    input  logic              rx_rst_n,
    input  logic              rx_orbit,
    input  logic              ch_enable,
    input  logic              err_clear,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_err
);
    localparam int PW = ADDR_W + 1;

    logic              wr_en;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [PW-1:0]     wgray_tx;
    logic [PW-1:0]     rgray_rx;
    logic [PW-1:0]     rgray_sync_tx;
    logic [PW-1:0]     wgray_sync_rx;
    logic              gap_rx;
    logic              ovf_tgl_tx;
    logic              ovf_tgl_rx;
    logic              rd_active;
    logic [DATA_W-1:0] mem_rdata;

    osf_write_ctrl #(.ADDR_W(ADDR_W), .DLY_W(DLY_W)) u_wr (
        .clk(tx_clk), .rst_n(tx_rst_n), .orbit(tx_orbit), .gap(tx_gap),
        .delay(sync_delay), .rgray_sync(rgray_sync_tx), .wr_en(wr_en),
        .waddr(waddr), .wgray(wgray_tx), .ovf_tgl(ovf_tgl_tx)
    );

    osf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wclk(tx_clk), .we(wr_en), .waddr(waddr), .wdata(tx_data),
        .raddr(raddr), .rdata(mem_rdata)
    );

    osf_sync #(.W(PW)) u_sync_rptr (
        .clk(tx_clk), .rst_n(tx_rst_n), .d(rgray_rx), .q(rgray_sync_tx)
    );

    osf_sync #(.W(PW)) u_sync_wptr (
        .clk(rx_clk), .rst_n(rx_rst_n), .d(wgray_tx), .q(wgray_sync_rx)
    );

    osf_sync #(.W(1)) u_sync_gap (
        .clk(rx_clk), .rst_n(rx_rst_n), .d(tx_gap), .q(gap_rx)
    );

    osf_sync #(.W(1)) u_sync_ovf (
        .clk(rx_clk), .rst_n(rx_rst_n), .d(ovf_tgl_tx), .q(ovf_tgl_rx)
    );

    osf_read_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .clk(rx_clk), .rst_n(rx_rst_n), .orbit(rx_orbit), .flush(gap_rx),
        .enable(ch_enable), .err_clear(err_clear), .wgray_sync(wgray_sync_rx),
        .ovf_tgl_sync(ovf_tgl_rx), .mem_data(mem_rdata), .raddr(raddr),
        .rgray(rgray_rx), .rd_active(rd_active), .data_out(rx_data),
        .err(rx_err)
    );
endmodule

// File: rtl/osf_checker.sv
// Property checker for orbit_sync_fifo, attached by bind below.
// Assumes the internal pointer and enable names of the top module.
module osf_checker #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 7
) (
    input logic              tx_clk,
    input logic              tx_rst_n,
    input logic              tx_gap,
    input logic              wr_en,
    input logic [ADDR_W:0]   wgray,
    input logic              rx_clk,
    input logic              rx_rst_n,
    input logic              flush_rx,
    input logic [ADDR_W:0]   rgray,
    input logic              ch_enable,
    input logic              err_clear,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_err
);
    // R5: the gap level blocks every write.
    a_r5_gap_blocks_write: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        tx_gap |-> !wr_en);

    // R2: the write pointer crosses as Gray code, one bit per edge outside flushes.
    a_r2_wgray_one_step: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        !$past(tx_gap) |-> ($countones(wgray ^ $past(wgray)) <= 1));

    // R3: the read pointer moves one Gray step at a time outside flushes.
    a_r3_rgray_one_step: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        !$past(flush_rx) |-> ($countones(rgray ^ $past(rgray)) <= 1));

    // R4: a masked lane shows zero after the edge.
    a_r4_disabled_zero: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        !ch_enable |=> (rx_data == '0));

    // R9: the flag falls only through a clear.
    a_r9_err_sticky: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        (rx_err && !err_clear) |=> rx_err);
endmodule

bind orbit_sync_fifo osf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .tx_clk(tx_clk), .tx_rst_n(tx_rst_n), .tx_gap(tx_gap), .wr_en(wr_en),
    .wgray(wgray_tx), .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .flush_rx(gap_rx),
    .rgray(rgray_rx), .ch_enable(ch_enable), .err_clear(err_clear),
    .rx_data(rx_data), .rx_err(rx_err)
);

// File: tb/orbit_sync_fifo_test.sv
// Scoreboard bench: the transmit driver queues every word the lane must
// store; the receive monitor pops and compares them as they come out.
module orbit_sync_fifo_test;
    localparam int DATA_W = 9;
    localparam int ADDR_W = 7;
    localparam int DLY_W  = 4;

    logic              tx_clk = 1'b0;
    logic              rx_clk = 1'b0;
    logic              tx_rst_n, rx_rst_n;
    logic [DATA_W-1:0] tx_data;
    logic              tx_orbit, tx_gap;
    logic [DLY_W-1:0]  sync_delay;
    logic              rx_orbit, ch_enable, err_clear;
    logic [DATA_W-1:0] rx_data;
    logic              rx_err;

    int total = 0;
    int bad   = 0;
    bit tx_stop;
    logic [DATA_W-1:0] q[$];

    orbit_sync_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DLY_W(DLY_W)) uut (
        .tx_clk(tx_clk), .tx_rst_n(tx_rst_n), .tx_data(tx_data),
        .tx_orbit(tx_orbit), .tx_gap(tx_gap), .sync_delay(sync_delay),
        .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .rx_orbit(rx_orbit),
        .ch_enable(ch_enable), .err_clear(err_clear), .rx_data(rx_data),
        .rx_err(rx_err)
    );

    // 100 MHz on both sides, receive clock shifted by 2 ns.
    always #5 tx_clk = ~tx_clk;
    initial begin
        #2;
        forever #5 rx_clk = ~rx_clk;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: marker at step 0 and again at step 15 (must be ignored, R6);
    // queue every word due for storage, then close with an 8-cycle gap.
    task automatic tx_run(input int dly, input int base, input int cap);
        int pushed = 0;
        sync_delay = DLY_W'(dly);
        for (int i = 0; !tx_stop; i++) begin
            @(negedge tx_clk);
            tx_data  = DATA_W'(base + i);
            tx_orbit = (i == 0) || (i == 15);
            if (i >= dly && pushed < cap) begin
                q.push_back(DATA_W'(base + i));
                pushed++;
            end
        end
        @(negedge tx_clk);
        tx_orbit = 1'b0;
        tx_gap   = 1'b1;
        repeat (8) @(negedge tx_clk);
        tx_gap = 1'b0;
    endtask

    // Monitor: common marker, then compare count words; optional mask window.
    task automatic rx_read(input int count, input bit mask_win, input string tag);
        bit en_used;
        logic [DATA_W-1:0] exp;
        @(negedge rx_clk);
        rx_orbit = 1'b1;
        @(negedge rx_clk);
        rx_orbit = 1'b0;
        check(rx_data == '0, "R3", int'(rx_data), 0);
        en_used = ch_enable;
        for (int n = 0; n < count; n++) begin
            @(negedge rx_clk);
            rx_orbit = (n == 5);
            if (q.size() == 0) begin
                check(1'b0, tag, 0, 1);
            end else begin
                exp = q.pop_front();
                if (en_used) check(rx_data == exp, tag, int'(rx_data), int'(exp));
                else         check(rx_data == '0, "R4", int'(rx_data), 0);
            end
            if (mask_win) ch_enable = !(n >= 7 && n < 11);
            en_used = ch_enable;
        end
        @(negedge rx_clk);
        rx_orbit  = 1'b0;
        ch_enable = 1'b1;
    endtask

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seen;
        logic [DATA_W-1:0] exp;
        tx_rst_n = 1'b0; rx_rst_n = 1'b0;
        tx_data = '0; tx_orbit = 1'b0; tx_gap = 1'b0; sync_delay = '0;
        rx_orbit = 1'b0; ch_enable = 1'b1; err_clear = 1'b0; tx_stop = 1'b0;
        repeat (4) @(negedge tx_clk);
        tx_rst_n = 1'b1; rx_rst_n = 1'b1;
        @(negedge rx_clk);
        check(rx_data == '0, "R1", int'(rx_data), 0);
        check(rx_err == 1'b0, "R1", int'(rx_err), 0);

        // Orbit with no delay, repeated markers and a masked window (R3, R6, R4).
        fork
            tx_run(0, 1, 1000);
            begin
                repeat (12) @(negedge rx_clk);
                rx_read(30, 1'b1, "R3/R6");
                tx_stop = 1'b1;
            end
        join
        q.delete(); tx_stop = 1'b0;
        repeat (6) @(negedge rx_clk);
        check(rx_data == '0, "R5", int'(rx_data), 0);
        check(rx_err == 1'b0, "R8", int'(rx_err), 0);

        // Delay 3 after a gap: first word is base+3, nothing left over (R2, R5).
        fork
            tx_run(3, 50, 1000);
            begin
                repeat (12) @(negedge rx_clk);
                rx_read(20, 1'b0, "R2/R5");
                tx_stop = 1'b1;
            end
        join
        q.delete(); tx_stop = 1'b0;
        repeat (6) @(negedge rx_clk);

        // Underflow: read armed with nothing stored (R8).
        @(negedge rx_clk); rx_orbit = 1'b1;
        @(negedge rx_clk); rx_orbit = 1'b0;
        repeat (4) @(negedge rx_clk);
        check(rx_err == 1'b1, "R8", int'(rx_err), 1);
        check(rx_data == '0, "R8", int'(rx_data), 0);
        fork
            tx_run(0, 200, 1000);
            begin
                seen = 0;
                for (int c = 0; c < 80 && seen < 10; c++) begin
                    @(negedge rx_clk);
                    if (rx_data != '0) begin
                        exp = q.pop_front();
                        check(rx_data == exp, "R8", int'(rx_data), int'(exp));
                        seen++;
                    end
                end
                check(seen == 10, "R8", seen, 10);
                tx_stop = 1'b1;
            end
        join
        q.delete(); tx_stop = 1'b0;
        repeat (6) @(negedge rx_clk);
        check(rx_err == 1'b1, "R9", int'(rx_err), 1);
        err_clear = 1'b1;
        @(negedge rx_clk);
        err_clear = 1'b0;
        check(rx_err == 1'b0, "R9", int'(rx_err), 0);

        // Overflow: 140 writes with no reads; first 128 words survive (R7).
        fork
            tx_run(0, 100, 128);
            begin
                repeat (140) @(negedge tx_clk);
                repeat (4) @(negedge rx_clk);
                check(rx_err == 1'b1, "R7", int'(rx_err), 1);
                rx_read(128, 1'b0, "R7");
                tx_stop = 1'b1;
            end
        join
        q.delete();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule